// File: doc/BRIEF.md
# Dual-Register Edge Input Capture

This block watches an asynchronous input pin, picks out the edges chosen by a two-bit capture mode, and copies the live timer count into one of two capture registers when such an edge arrives. The first edge that qualifies fills the first register and the second fills the second. After that the block ignores the pin until software re-arms it. Software re-arms it in one of two ways: it writes a one to the capture status bit, or it changes the capture mode from "none" to one of the edge modes.

A single-cycle capture event strobe goes to the interrupt status logic. The second-capture select decides whether the strobe follows the first capture or the second. The counter and the interrupt status register sit outside this block. The block sees the count only as an input bus and reports only the strobe.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset both capture registers read zero and the capture event strobe is low.
- R2: Mode 1 captures on rising edges only. A falling edge leaves both registers unchanged.
- R3: Mode 2 captures on falling edges only. A rising edge leaves both registers unchanged.
- R4: Mode 3 captures on both rising and falling edges.
- R5: Mode 0 never captures, whatever the pin does.
- R6: No capture takes place while `pin_is_input` is 0, in any mode.
- R7: The first qualifying edge after arming loads `cap_first`. The second loads `cap_second`. Every later edge is ignored until the block is re-armed.
- R8: With `second_sel` = 0, `cap_event` is high for exactly one cycle, alongside the first capture. With `second_sel` = 1, it is high for exactly one cycle, alongside the second capture.
- R9: A one-cycle pulse on `arm_clr` sets the capture count back to zero, so the next qualifying edge loads `cap_first` again.
- R10: A change of `cap_mode` from 0 to any non-zero value sets the capture count back to zero.
- R11: Holding the pin high through reset and beyond produces no capture and no event. The first level sampled after reset serves as the previous level.
- R12: The pin passes through a two-flop synchronizer. The value captured is the `count_in` present at the third rising clock edge after the pin changes, and the register and `cap_event` change at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 1 | External capture pin, not synchronized |
| count_in | input | 32 | Live timer count |
| cap_mode | input | 2 | 0 none, 1 rising, 2 falling, 3 both |
| second_sel | input | 1 | 0: event on first capture, 1: event on second |
| pin_is_input | input | 1 | 1 when the pin is set up as an input |
| arm_clr | input | 1 | Re-arm pulse from a status-bit write |
| cap_first | output | 32 | First capture register |
| cap_second | output | 32 | Second capture register |
| cap_event | output | 1 | One-cycle capture event strobe |

## Verification
The pin is driven with patterns made of rising and falling edges, under each mode. A distinct count value is held for every edge, so the stored values show which edges were taken and which register each one went to. Runs of three or four edges at each `second_sel` setting separate the first-capture event from the second and confirm that the block stops after two captures. The re-arm tests clear the count through `arm_clr` and through a mode change from none, and a moving count shows the exact synchronizer latency. A pin held high across reset, and edges arriving while the pin is set as an output, should both leave the registers at zero.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;
    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_mode_e;

    localparam int unsigned SLOT_COUNT = 2;
endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic level,
    output logic level_prev,
    output logic primed
);
    localparam int unsigned FILL_W = STAGES + 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
        logic [FILL_W-1:0] fill;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin_async};
        st_d.prev  = st_q.chain[STAGES-1];
        st_d.fill  = {st_q.fill[FILL_W-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level      = st_q.chain[STAGES-1];
    assign level_prev = st_q.prev;
    assign primed     = st_q.fill[FILL_W-1];
endmodule

// File: rtl/ecap_edge.sv
module ecap_edge
    import edge_cap_pkg::*;
(
    input  cap_mode_e mode,
    input  logic      level,
    input  logic      level_prev,
    input  logic      primed,
    output logic      hit
);
    logic rise, fall;

    always_comb begin
        rise = primed & level & ~level_prev;
        fall = primed & ~level & level_prev;
        unique case (mode)
            CAP_RISE: hit = rise;
            CAP_FALL: hit = fall;
            CAP_BOTH: hit = rise | fall;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ecap_store.sv
module ecap_store
    import edge_cap_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             pin_is_input,
    input  cap_mode_e        mode,
    input  logic             second_sel,
    input  logic             arm_clr,
    input  logic [CNT_W-1:0] count_in,
    output logic [CNT_W-1:0] cap_first,
    output logic [CNT_W-1:0] cap_second,
    output logic             cap_event
);
    localparam int unsigned NUM_W = $clog2(SLOT_COUNT + 1);
    localparam logic [NUM_W-1:0] FULL = NUM_W'(SLOT_COUNT);

    typedef struct packed {
        logic [NUM_W-1:0] num;
        logic [CNT_W-1:0] first;
        logic [CNT_W-1:0] second;
        logic             evt;
        cap_mode_e        mode_prev;
    } store_t;

    store_t sv_d, sv_q;
    logic   rearm;
    logic   take;

    always_comb begin
        sv_d           = sv_q;
        sv_d.evt       = 1'b0;
        sv_d.mode_prev = mode;
        rearm = arm_clr | ((sv_q.mode_prev == CAP_OFF) && (mode != CAP_OFF));
        take  = hit & pin_is_input & (sv_q.num != FULL);
        if (rearm) begin
            sv_d.num = '0;
        end else if (take) begin
            if (sv_q.num == '0) sv_d.first  = count_in;
            else                sv_d.second = count_in;
            sv_d.num = sv_q.num + 1'b1;
            sv_d.evt = (sv_q.num[0] == second_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sv_q           <= '0;
            sv_q.mode_prev <= CAP_OFF;
        end else begin
            sv_q <= sv_d;
        end
    end

    assign cap_first  = sv_q.first;
    assign cap_second = sv_q.second;
    assign cap_event  = sv_q.evt;
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import edge_cap_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_async,
    input  logic [CNT_W-1:0] count_in,
    input  logic [1:0]       cap_mode,
    input  logic             second_sel,
    input  logic             pin_is_input,
    input  logic             arm_clr,
    output logic [CNT_W-1:0] cap_first,
    output logic [CNT_W-1:0] cap_second,
    output logic             cap_event
);
    cap_mode_e mode;
    logic      level, level_prev, primed, hit;

    assign mode = cap_mode_e'(cap_mode);

    ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (pin_async),
        .level      (level),
        .level_prev (level_prev),
        .primed     (primed)
    );

    ecap_edge u_edge (
        .mode       (mode),
        .level      (level),
        .level_prev (level_prev),
        .primed     (primed),
        .hit        (hit)
    );

    ecap_store #(.CNT_W(CNT_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (hit),
        .pin_is_input (pin_is_input),
        .mode         (mode),
        .second_sel   (second_sel),
        .arm_clr      (arm_clr),
        .count_in     (count_in),
        .cap_first    (cap_first),
        .cap_second   (cap_second),
        .cap_event    (cap_event)
    );
endmodule

// File: rtl/ecap_checker.sv
module ecap_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cap_mode,
    input logic             pin_is_input,
    input logic [CNT_W-1:0] cap_first,
    input logic [CNT_W-1:0] cap_second,
    input logic             cap_event
);
    logic [2:0] cyc_q;
    logic       seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
        end
    end

    // R6: registers hold while the pin is an output
    p_hold_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(pin_is_input)) |-> ($stable(cap_first) && $stable(cap_second)));

    // R5: registers hold in mode none
    p_hold_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ($past(cap_mode) == 2'd0)) |-> ($stable(cap_first) && $stable(cap_second)));

    // R8: the strobe needs an enabled capture path in the cycle before
    p_event_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cap_event) |-> ($past(pin_is_input) && ($past(cap_mode) != 2'd0)));

    // R11: nothing is captured while the synchronizer is still filling
    p_no_false_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q < 3'd4) |-> (!cap_event && (cap_first == '0) && (cap_second == '0)));
endmodule

bind edge_capture_unit ecap_checker #(.CNT_W(CNT_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_mode     (cap_mode),
    .pin_is_input (pin_is_input),
    .cap_first    (cap_first),
    .cap_second   (cap_second),
    .cap_event    (cap_event)
);

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_async = 1'b0;
    logic [31:0] count_in = '0;
    logic [1:0]  cap_mode = 2'd0;
    logic        second_sel = 1'b0;
    logic        pin_is_input = 1'b0;
    logic        arm_clr = 1'b0;
    logic [31:0] cap_first, cap_second;
    logic        cap_event;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    edge_capture_unit i_edge_capture_unit (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .count_in(count_in),
        .cap_mode(cap_mode), .second_sel(second_sel), .pin_is_input(pin_is_input),
        .arm_clr(arm_clr), .cap_first(cap_first), .cap_second(cap_second),
        .cap_event(cap_event)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic pin_lvl, input logic [1:0] mode,
                            input logic sel, input logic dir);
        @(negedge clk);
        rst_n = 1'b0; pin_async = pin_lvl; cap_mode = mode;
        second_sel = sel; pin_is_input = dir; arm_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // drive the pin with a held count, return number of strobes seen
    task automatic drive_pin(input logic v, input logic [31:0] cnt, output int nev);
        @(negedge clk);
        pin_async = v; count_in = cnt; nev = 0;
        repeat (4) begin
            @(negedge clk);
            if (cap_event) nev++;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 first after reset", cap_first, 0);
        chk("R1 second after reset", cap_second, 0);
        chk("R1 event after reset", {31'd0, cap_event}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_rising;
        int n;
        do_reset(1'b0, 2'd1, 1'b0, 1'b1);
        drive_pin(1'b1, 32'd100, n);
        chk("R2 rise capture first", cap_first, 100);
        chk("R8 sel0 event on first", n, 1);
        drive_pin(1'b0, 32'd200, n);
        chk("R2 fall ignored first", cap_first, 100);
        chk("R2 fall ignored second", cap_second, 0);
        drive_pin(1'b1, 32'd300, n);
        chk("R7 second capture", cap_second, 300);
        chk("R8 sel0 no event on second", n, 0);
    endtask

    task automatic t_falling;
        int n;
        do_reset(1'b0, 2'd2, 1'b0, 1'b1);
        drive_pin(1'b1, 32'd11, n);
        chk("R3 rise ignored", cap_first, 0);
        drive_pin(1'b0, 32'd22, n);
        chk("R3 fall captured", cap_first, 22);
        chk("R3 event", n, 1);
    endtask

    task automatic t_both;
        int n;
        do_reset(1'b0, 2'd3, 1'b1, 1'b1);
        drive_pin(1'b1, 32'd5, n);
        chk("R4 rise to first", cap_first, 5);
        chk("R8 sel1 no event on first", n, 0);
        drive_pin(1'b0, 32'd6, n);
        chk("R4 fall to second", cap_second, 6);
        chk("R8 sel1 event on second", n, 1);
        drive_pin(1'b1, 32'd7, n);
        chk("R7 third edge first kept", cap_first, 5);
        chk("R7 third edge second kept", cap_second, 6);
        chk("R7 third edge no event", n, 0);
    endtask

    task automatic t_none;
        int n;
        int ev = 0;
        do_reset(1'b0, 2'd0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            drive_pin(i[0] ? 1'b0 : 1'b1, 32'(50 + i), n);
            ev += n;
        end
        chk("R5 none first", cap_first, 0);
        chk("R5 none second", cap_second, 0);
        chk("R5 none events", ev, 0);
    endtask

    task automatic t_output;
        int n;
        int ev = 0;
        do_reset(1'b0, 2'd3, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            drive_pin(i[0] ? 1'b0 : 1'b1, 32'(70 + i), n);
            ev += n;
        end
        chk("R6 output first", cap_first, 0);
        chk("R6 output second", cap_second, 0);
        chk("R6 output events", ev, 0);
    endtask

    task automatic t_clear;
        int n;
        do_reset(1'b0, 2'd1, 1'b0, 1'b1);
        drive_pin(1'b1, 32'd10, n);
        drive_pin(1'b0, 32'd15, n);
        @(negedge clk); arm_clr = 1'b1;
        @(negedge clk); arm_clr = 1'b0;
        drive_pin(1'b1, 32'd20, n);
        chk("R9 rearm loads first", cap_first, 20);
        chk("R9 rearm second untouched", cap_second, 0);
        chk("R9 rearm event", n, 1);
    endtask

    task automatic t_mode;
        int n;
        do_reset(1'b0, 2'd1, 1'b0, 1'b1);
        drive_pin(1'b1, 32'd10, n);
        drive_pin(1'b0, 32'd15, n);
        drive_pin(1'b1, 32'd20, n);
        drive_pin(1'b0, 32'd25, n);
        @(negedge clk); cap_mode = 2'd0;
        @(negedge clk); cap_mode = 2'd2;
        drive_pin(1'b1, 32'd30, n);
        drive_pin(1'b0, 32'd40, n);
        chk("R10 mode rearm first", cap_first, 40);
        chk("R10 mode rearm second kept", cap_second, 20);
        chk("R10 mode rearm event", n, 1);
    endtask

    task automatic t_no_false;
        int ev = 0;
        @(negedge clk);
        rst_n = 1'b0; pin_async = 1'b1; cap_mode = 2'd3;
        pin_is_input = 1'b1; second_sel = 1'b0; count_in = 32'd99;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (cap_event) ev++;
        end
        chk("R11 no false first", cap_first, 0);
        chk("R11 no false event", ev, 0);
    endtask

    task automatic t_latency;
        do_reset(1'b0, 2'd1, 1'b0, 1'b1);
        @(negedge clk);
        pin_async = 1'b1; count_in = 32'd1000;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (i == 2) chk("R12 not yet captured", cap_first, 0);
            if (i == 3) chk("R12 event at third edge", {31'd0, cap_event}, 1);
            count_in = 32'd1000 + 32'(i);
        end
        chk("R12 captured count", cap_first, 1002);
    endtask

    initial begin
        t_reset();
        t_rising();
        t_falling();
        t_both();
        t_none();
        t_output();
        t_clear();
        t_mode();
        t_no_false();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule